// File: doc/BRIEF.md
# Stereo Gain Glide with Soft Mute

This block sits in a digital audio playback path between the sample source and the modulator. Each channel holds a requested 14-bit unsigned linear volume word and a current gain. The current gain walks toward the requested word so that large volume changes do not produce audible clicks. Each 24-bit two's-complement sample is then multiplied by the current gain of its channel.

Volume writes arrive as single-cycle pulses that carry a channel select. A write is held until the next frame tick, which is a one-cycle pulse per sample period. At that tick the write becomes the channel's target. On every frame tick the upper ten bits of the gain move one step toward the target. The lower four bits take the target's value at once. A mute request comes from a pin and from a control bit, and the two are ORed together. Mute acts on both channels through the same ramp: while mute is asserted the effective target is zero. When mute is released, each gain climbs back to its stored target.

Top module: `gain_glide`

## Requirements
- R1: During reset and directly after it, both gains (`gain_l`, `gain_r`), both stored targets and both outputs are zero.
- R2: A write (`wr_en` high for one cycle, `wr_sel` 0 selects left and 1 selects right) changes no gain until the next `frame_tick`. If several writes reach one channel before that tick, only the last one is used.
- R3: At the first frame tick after a write, bits [3:0] of that channel's gain take the value of bits [3:0] of the written word, in that same tick.
- R4: On each frame tick, bits [13:4] of a gain move exactly one count toward the effective target. They stop at the target without overshoot and do not change between ticks.
- R5: Each channel ramps from its own target. A write to one channel never changes the other channel's gain.
- R6: Mute is `mute_pin` OR `mute_bit`, and it is sampled at frame ticks. While mute is asserted, the effective target of both channels is zero. At a tick under mute, bits [3:0] of each gain become zero and bits [13:4] ramp down one count per tick until they reach zero and stay there.
- R7: Once mute is released, each gain ramps back up to its stored target. This includes a target written while the block was muted.
- R8: Each output register is loaded on every clock with floor(s × m / 16384), where s is the channel's sample, m = g + g[13] and g is the channel's current gain. With g = 14'h3FFF the output therefore equals the sample exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle pulse per sample period (frame boundary) |
| wr_en | input | 1 | Volume write strobe |
| wr_sel | input | 1 | Write channel: 0 left, 1 right |
| wr_vol | input | 14 | Requested unsigned volume word |
| mute_pin | input | 1 | Hardware mute request |
| mute_bit | input | 1 | Control-bit mute request |
| smp_l | input | 24 | Left sample, two's complement |
| smp_r | input | 24 | Right sample, two's complement |
| out_l | output | 24 | Scaled left sample |
| out_r | output | 24 | Scaled right sample |
| gain_l | output | 14 | Current left gain |
| gain_r | output | 14 | Current right gain |

## Verification
The bench ramps a gain across the whole 10-bit upper range and checks the scaled output at every step against floor arithmetic. Each step uses a fresh sample, and the full-scale extremes are included, so a product with the wrong sign handling or truncation shows up as a mismatch. It then runs a full ramp past the target. A ramp that overshoots, or that keeps wrapping, shows up at the end. It also sends two writes before a single tick, so a design that applied writes immediately, or that kept the first write, exposes a wrong gain. Mute is checked through the pin and then through the bit, with a write made during mute. A design that forgot that target, or that held mute only on one source, would fail to settle back at the written word after release.

// File: rtl/gain_glide_pkg.sv
package gain_glide_pkg;
   localparam int unsigned CH_LEFT  = 0;
   localparam int unsigned CH_RIGHT = 1;
   localparam int unsigned NUM_CH   = 2;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_dir_t;
endpackage

// File: rtl/gain_glide_pend.sv
module gain_glide_pend #(
   parameter int unsigned GW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr_en,
   input  logic [GW-1:0] wr_data,
   output logic [GW-1:0] tgt_now
);
   logic [GW-1:0] held_q;
   logic          held_v;
   logic [GW-1:0] tgt_q;

   assign tgt_now = held_v ? held_q : tgt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         held_v <= 1'b0;
         tgt_q  <= '0;
      end else begin
         if (tick) begin
            tgt_q <= tgt_now;
         end
         if (wr_en) begin
            held_q <= wr_data;
            held_v <= 1'b1;
         end else if (tick) begin
            held_v <= 1'b0;
         end
      end
   end

   // R2: the stored target only moves on a frame tick
   a_r2_hold_off_tick : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(tgt_q));
endmodule

// File: rtl/gain_glide_ramp.sv
module gain_glide_ramp
   import gain_glide_pkg::*;
#(
   parameter int unsigned GW = 14,
   parameter int unsigned RW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          mute,
   input  logic [GW-1:0] tgt,
   output logic [GW-1:0] gain
);
   localparam int unsigned LW = GW - RW;

   logic [RW-1:0] hi_q;
   logic [LW-1:0] lo_q;
   logic [GW-1:0] eff;
   step_dir_t     dir;

   assign eff  = mute ? '0 : tgt;
   assign gain = {hi_q, lo_q};

   always_comb begin
      if (hi_q < eff[GW-1:LW])      dir = STEP_UP;
      else if (hi_q > eff[GW-1:LW]) dir = STEP_DOWN;
      else                          dir = STEP_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (tick) begin
         lo_q <= eff[LW-1:0];
         case (dir)
            STEP_UP:   hi_q <= hi_q + 1'b1;
            STEP_DOWN: hi_q <= hi_q - 1'b1;
            default:   hi_q <= hi_q;
         endcase
      end
   end

   a_r4_step_limit : assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (hi_q == $past(hi_q)) || (hi_q == $past(hi_q) + 1'b1) ||
               (hi_q == $past(hi_q) - 1'b1));

   a_r4_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(gain));

   a_r6_mute_floor : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mute && hi_q == '0) |=> (gain == '0));
endmodule

// File: rtl/gain_glide_scale.sv
module gain_glide_scale #(
   parameter int unsigned DW = 24,
   parameter int unsigned GW = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [DW-1:0] smp,
   input  logic        [GW-1:0] gain,
   output logic signed [DW-1:0] out
);
   localparam int unsigned MW = GW + 1;
   localparam int unsigned PW = DW + MW + 1;

   logic        [MW-1:0] mult;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shifted;

   assign mult    = {1'b0, gain} + {{GW{1'b0}}, gain[GW-1]};
   assign prod    = PW'(smp) * $signed({1'b0, mult});
   assign shifted = prod >>> GW;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out <= '0;
      else        out <= shifted[DW-1:0];
   end

   // R8: full gain passes the sample through unchanged
   a_r8_unity_pass : assert property (@(posedge clk) disable iff (!rst_n)
      (gain == {GW{1'b1}}) |=> (out == $past(smp)));
endmodule

// File: rtl/gain_glide.sv
module gain_glide
   import gain_glide_pkg::*;
#(
   parameter int unsigned DW = 24,
   parameter int unsigned GW = 14,
   parameter int unsigned RW = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_tick,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic        [GW-1:0] wr_vol,
   input  logic                 mute_pin,
   input  logic                 mute_bit,
   input  logic signed [DW-1:0] smp_l,
   input  logic signed [DW-1:0] smp_r,
   output logic signed [DW-1:0] out_l,
   output logic signed [DW-1:0] out_r,
   output logic        [GW-1:0] gain_l,
   output logic        [GW-1:0] gain_r
);
   if (RW < 1 || RW >= GW) begin : g_bad_rw
      $error("gain_glide: RW must lie in 1..GW-1");
   end
   if (DW < 2) begin : g_bad_dw
      $error("gain_glide: DW too small");
   end

   logic                 mute;
   logic signed [DW-1:0] smp_a [NUM_CH];
   logic signed [DW-1:0] out_a [NUM_CH];
   logic        [GW-1:0] gain_a [NUM_CH];

   assign mute            = mute_pin | mute_bit;
   assign smp_a[CH_LEFT]  = smp_l;
   assign smp_a[CH_RIGHT] = smp_r;
   assign out_l           = out_a[CH_LEFT];
   assign out_r           = out_a[CH_RIGHT];
   assign gain_l          = gain_a[CH_LEFT];
   assign gain_r          = gain_a[CH_RIGHT];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic          sel_me;
      logic [GW-1:0] tgt;

      assign sel_me = wr_en && (wr_sel == 1'(c));

      gain_glide_pend #(.GW(GW)) u_pend (
         .clk(clk), .rst_n(rst_n), .tick(frame_tick),
         .wr_en(sel_me), .wr_data(wr_vol), .tgt_now(tgt)
      );

      gain_glide_ramp #(.GW(GW), .RW(RW)) u_ramp (
         .clk(clk), .rst_n(rst_n), .tick(frame_tick),
         .mute(mute), .tgt(tgt), .gain(gain_a[c])
      );

      gain_glide_scale #(.DW(DW), .GW(GW)) u_scale (
         .clk(clk), .rst_n(rst_n), .smp(smp_a[c]),
         .gain(gain_a[c]), .out(out_a[c])
      );
   end

   // R5: a write to one channel leaves the other channel's gain alone off tick
   a_r5_chan_isolation : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !frame_tick) |=> $stable(gain_l) && $stable(gain_r));
endmodule

// File: tb/sim_gain_glide.sv
module sim_gain_glide;
   logic clk = 1'b0;
   logic rst_n, frame_tick, wr_en, wr_sel, mute_pin, mute_bit;
   logic [13:0] wr_vol;
   logic signed [23:0] smp_l, smp_r, out_l, out_r;
   logic [13:0] gain_l, gain_r;

   int checks = 0, errors = 0;
   logic [31:0] seed = 32'h1234_5678;
   int k = 0;

   logic [9:0]  mhi [2];
   logic [3:0]  mlo [2];
   logic [13:0] mtgt [2];
   logic [13:0] mpd [2];
   logic        mpv [2];

   always #5 clk = ~clk;

   gain_glide u0 (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_vol(wr_vol), .mute_pin(mute_pin), .mute_bit(mute_bit),
      .smp_l(smp_l), .smp_r(smp_r), .out_l(out_l), .out_r(out_r),
      .gain_l(gain_l), .gain_r(gain_r)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint scaled(input logic signed [23:0] s, input logic [13:0] g);
      longint m = longint'(g) + longint'(g[13]);
      longint p = longint'(s) * m;
      return p >>> 14;
   endfunction

   task automatic wr(input bit ch, input logic [13:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = ch; wr_vol = v;
      @(negedge clk);
      wr_en = 1'b0;
      mpd[ch] = v; mpv[ch] = 1'b1;
   endtask

   task automatic do_tick(input string tag);
      logic [13:0] eff;
      @(negedge clk);
      seed = seed * 32'd1103515245 + 32'd12345;
      case (k % 8)
         0: begin smp_l = 24'sh800000; smp_r = 24'sh7FFFFF; end
         1: begin smp_l = 24'sh7FFFFF; smp_r = -24'sd1; end
         default: begin smp_l = seed[23:0]; smp_r = seed[31:8]; end
      endcase
      k++;
      frame_tick = 1'b1;
      for (int c = 0; c < 2; c++) begin
         if (mpv[c]) mtgt[c] = mpd[c];
         mpv[c] = 1'b0;
         eff = (mute_pin | mute_bit) ? 14'd0 : mtgt[c];
         mlo[c] = eff[3:0];
         if (mhi[c] < eff[13:4]) mhi[c] = mhi[c] + 1'b1;
         else if (mhi[c] > eff[13:4]) mhi[c] = mhi[c] - 1'b1;
      end
      @(negedge clk);
      frame_tick = 1'b0;
      chk(gain_l == {mhi[0], mlo[0]}, {tag, " gain_l"}, gain_l, {mhi[0], mlo[0]});
      chk(gain_r == {mhi[1], mlo[1]}, {tag, " gain_r"}, gain_r, {mhi[1], mlo[1]});
      @(negedge clk);
      chk(longint'(out_l) == scaled(smp_l, gain_l), "R8 out_l", out_l, scaled(smp_l, gain_l));
      chk(longint'(out_r) == scaled(smp_r, gain_r), "R8 out_r", out_r, scaled(smp_r, gain_r));
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; frame_tick = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_vol = '0;
      mute_pin = 1'b0; mute_bit = 1'b0; smp_l = 24'sd1000; smp_r = -24'sd1000;
      for (int c = 0; c < 2; c++) begin
         mhi[c] = '0; mlo[c] = '0; mtgt[c] = '0; mpd[c] = '0; mpv[c] = 1'b0;
      end
      repeat (3) @(negedge clk);
      chk(gain_l == 0 && gain_r == 0, "R1 gains in reset", gain_l, 0);
      chk(out_l == 0 && out_r == 0, "R1 outputs in reset", out_l, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(out_l == 0, "R1 out_l after reset", out_l, 0);

      // R2: write held until the frame tick
      wr(1'b0, 14'h3FFF);
      repeat (3) @(negedge clk);
      chk(gain_l == 0, "R2 no change before tick", gain_l, 0);
      do_tick("R3");
      chk(gain_l == 14'h001F, "R3 low bits at once", gain_l, 14'h001F);
      chk(gain_r == 0, "R5 right untouched", gain_r, 0);

      // R4: full ramp with output checks at every gain
      for (int i = 0; i < 1030; i++) do_tick("R4");
      chk(gain_l == 14'h3FFF, "R4 stop at target", gain_l, 14'h3FFF);

      // R8: unity passes exact samples
      @(negedge clk); smp_l = 24'sh800000;
      @(negedge clk); @(negedge clk);
      chk(out_l == 24'sh800000, "R8 unity min", out_l, -8388608);
      smp_l = 24'sh7FFFFF;
      @(negedge clk); @(negedge clk);
      chk(out_l == 24'sh7FFFFF, "R8 unity max", out_l, 8388607);

      // R5: right channel ramps alone
      wr(1'b1, 14'h0123);
      do_tick("R3 right");
      chk(gain_r == 14'h0013, "R3 right low bits", gain_r, 14'h0013);
      for (int i = 0; i < 20; i++) do_tick("R5");
      chk(gain_r == 14'h0123 && gain_l == 14'h3FFF, "R5 independent", gain_r, 14'h0123);

      // R2: last write wins
      wr(1'b0, 14'h1000);
      wr(1'b0, 14'h2008);
      do_tick("R2");
      chk(gain_l == {10'd1022, 4'h8}, "R2 latest write", gain_l, {10'd1022, 4'h8});

      // R6: mute through pin, write during mute
      mute_pin = 1'b1;
      do_tick("R6");
      chk(gain_l[3:0] == 0 && gain_r[3:0] == 0, "R6 low bits cleared", gain_l, 14'h3FD0);
      wr(1'b1, 14'h3FF0);
      for (int i = 0; i < 1030; i++) do_tick("R6");
      chk(gain_l == 0 && gain_r == 0, "R6 muted floor", gain_l, 0);
      mute_pin = 1'b0; mute_bit = 1'b1;
      for (int i = 0; i < 5; i++) do_tick("R6 bit");
      chk(gain_l == 0 && gain_r == 0, "R6 bit mute holds", gain_r, 0);

      // R7: unmute ramps back to stored targets
      mute_bit = 1'b0;
      for (int i = 0; i < 1030; i++) do_tick("R7");
      chk(gain_l == 14'h2008, "R7 left restored", gain_l, 14'h2008);
      chk(gain_r == 14'h3FF0, "R7 right restored", gain_r, 14'h3FF0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule